// File: doc/BRIEF.md
# Consumer Channel Status Generator

This block produces the 192-bit consumer channel status sequence that a serial digital audio transmitter sends, one bit per audio frame. A frame counter picks the status bit for the current frame. A block-start strobe marks frame 0 of every block. The status contents come from static configuration pins: copy inhibit, pre-emphasis, a two-bit category field, the generation flag and a two-bit sample-rate code. Every bit that no pin or subcode field drives is sent as zero.

Setting the sample-rate code to its reserved value `11` selects a compact-disc submode. In this submode the block-start output is repurposed and held low. Three subcode lines then act as a receiver for subcode Q bits. A subcode block begins when the subcode frame line stays high for more than a set number of subcode clock edges. After that start, the first, third and fourth Q bits drive status bits 5, 2 and 3. The category field is forced to the CD category. The decoded bits wait in a pending register and reach the outgoing sequence only at the next status block boundary, so a single block never mixes old and new values.

Top module: `cs_consumer_gen`

## Requirements
- R1: A synchronous active-high reset returns the frame index to 0 (block_start high when not in CD submode) and clears both the pending and the applied subcode bits.
- R2: Each frame_strobe pulse advances the frame index by one. The index wraps to 0 after frame 191. block_start is high exactly during frame 0 when not in CD submode.
- R3: Outside CD submode, status bit 2 is the inverse of copy_inhibit, so a high pin sends 0.
- R4: Outside CD submode, bit 3 follows emph_on, bit 8 follows category[0], bit 9 follows category[1], and bit 15 follows generation.
- R5: fs_code maps to status bits {bit24, bit25} as 00→00, 01→01, 10→11 and 11→00.
- R6: With fs_code = 11 (CD submode), block_start stays 0, bit 8 is 1, bit 9 is 0 whatever the category pins are, bits 24/25 are 0, and bit 15 still follows generation.
- R7: A subcode block starts when sub_frame falls after more than 16 rising sub_clk edges seen while it was high. The 1st, 3rd and 4th rising sub_clk edges after that, taken while sub_frame is low, capture sub_data into status bits 5, 2 and 3. These bits are used in CD submode.
- R8: Rising sub_clk edges while sub_frame is high capture no data. A high phase with 16 or fewer edges starts no subcode block, and no further Q bits are taken after the fourth.
- R9: Newly captured subcode bits appear in the output only from frame 0 of the block that follows the capture. The applied bits change only at a wrap.
- R10: Every status bit not named in R3 to R7 is sent as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | One-cycle pulse per audio frame; advances the index |
| copy_inhibit | input | 1 | High forbids copying (status bit 2 = 0) |
| emph_on | input | 1 | Pre-emphasis flag for bit 3 |
| category | input | 2 | Category field for bits 8 and 9 |
| generation | input | 1 | Generation flag for bit 15 |
| fs_code | input | 2 | Sample-rate code; 11 selects CD submode |
| sub_frame | input | 1 | Subcode frame line |
| sub_clk | input | 1 | Subcode bit clock, rising edge active |
| sub_data | input | 1 | Subcode Q data |
| cs_bit | output | 1 | Status bit for the current frame |
| block_start | output | 1 | High during frame 0 outside CD submode |

## Verification
The bench checks every frame of whole blocks under three distinct pin patterns. The patterns flip copy, emphasis, category and generation between blocks, so a swapped or stuck bit position shows up as a mismatch at a specific frame. Each of the three plain sample-rate codes is run once, which separates the four-entry mapping from a plain copy of the pins.

In CD submode, the category pins are set to 11 so that forcing the category is visible. The subcode stimulus is built to expose specific faults:
- A 16-edge high phase, followed by a 17-edge high phase, tests the start threshold on both sides.
- Q patterns with a distinct value in the 2nd position catch an off-by-one in bit selection.
- Comparing the block right after a capture with the block after that confirms that updates wait for the boundary.

A reset mid-block proves that the captured bits are cleared.

// File: rtl/cscg_pkg.sv
package cscg_pkg;

    // Status bit positions whose meaning the receiver side decodes
    localparam int unsigned POS_COPY  = 2;
    localparam int unsigned POS_EMPH  = 3;
    localparam int unsigned POS_SUB5  = 5;
    localparam int unsigned POS_CAT0  = 8;
    localparam int unsigned POS_CAT1  = 9;
    localparam int unsigned POS_GEN   = 15;
    localparam int unsigned POS_FS0   = 24;
    localparam int unsigned POS_FS1   = 25;

    typedef enum logic [1:0] {
        FS_44K  = 2'b00,
        FS_48K  = 2'b01,
        FS_32K  = 2'b10,
        FS_CDSM = 2'b11
    } fs_code_e;

    typedef struct packed {
        logic     copy_inh;
        logic     emph;
        logic [1:0] cat;
        logic     gen;
        fs_code_e fs;
    } pin_cfg_t;

    // Q-derived status bits
    typedef struct packed {
        logic b5;
        logic b2;
        logic b3;
    } sub_bits_t;

    // Returns {bit25, bit24}
    function automatic logic [1:0] fs_to_bits(input fs_code_e fs);
        logic [1:0] r;
        case (fs)
            FS_44K:  r = 2'b00;
            FS_48K:  r = 2'b10;
            FS_32K:  r = 2'b11;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    function automatic logic is_cd(input fs_code_e fs);
        return fs == FS_CDSM;
    endfunction

endpackage

// File: rtl/cscg_frame_counter.sv
module cscg_frame_counter #(
    parameter int unsigned FRAMES = 192,
    localparam int unsigned IW    = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    output logic [IW-1:0] idx,
    output logic          wrap,
    output logic          first
);
    localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);

    assign wrap  = strobe && (idx == LAST);
    assign first = (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (strobe) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/cscg_subcode_rx.sv
module cscg_subcode_rx
    import cscg_pkg::*;
#(
    parameter int unsigned START_EDGES = 16,
    parameter int unsigned Q_TAKEN     = 4,
    localparam int unsigned HW = $clog2(START_EDGES + 2),
    localparam int unsigned QW = $clog2(Q_TAKEN + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sub_frame,
    input  logic      sub_clk,
    input  logic      sub_data,
    input  logic      apply,
    output sub_bits_t pending,
    output sub_bits_t applied
);
    localparam logic [HW-1:0] HI_SAT = HW'(START_EDGES + 1);
    localparam logic [QW-1:0] Q_END  = QW'(Q_TAKEN);

    logic frm_q, frm_prev, clk_q, clk_prev, dat_q;
    logic [HW-1:0] hi_cnt;
    logic [QW-1:0] q_idx;
    logic          started;
    logic          edge_r, frm_fall;

    assign edge_r   = clk_q && !clk_prev;
    assign frm_fall = frm_prev && !frm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q    <= 1'b0;
            frm_prev <= 1'b0;
            clk_q    <= 1'b0;
            clk_prev <= 1'b0;
            dat_q    <= 1'b0;
        end else begin
            frm_q    <= sub_frame;
            frm_prev <= frm_q;
            clk_q    <= sub_clk;
            clk_prev <= clk_q;
            dat_q    <= sub_data;
        end
    end

    // High-phase edge counter and block-start detection
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= '0;
            started <= 1'b0;
        end else if (frm_q) begin
            if (edge_r && hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            if (frm_fall && hi_cnt == HI_SAT) started <= 1'b1;
            hi_cnt <= '0;
        end
    end

    // Q bit capture during the low phase
    always_ff @(posedge clk) begin
        if (rst) begin
            q_idx   <= '0;
            pending <= '0;
        end else if (!frm_q && frm_fall && hi_cnt == HI_SAT) begin
            q_idx <= '0;
        end else if (!frm_q && edge_r && started && q_idx != Q_END) begin
            case (q_idx)
                QW'(0): pending.b5 <= dat_q;
                QW'(2): pending.b2 <= dat_q;
                QW'(3): pending.b3 <= dat_q;
                default: ;
            endcase
            q_idx <= q_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        applied <= '0;
        else if (apply) applied <= pending;
    end
endmodule

// File: rtl/cscg_status_builder.sv
module cscg_status_builder
    import cscg_pkg::*;
#(
    parameter int unsigned FRAMES = 192,
    localparam int unsigned IW    = $clog2(FRAMES)
) (
    input  pin_cfg_t      cfg,
    input  sub_bits_t     sub,
    input  logic [IW-1:0] idx,
    output logic          bit_out
);
    logic [FRAMES-1:0] vec;
    logic [1:0]        fsb;

    always_comb begin
        fsb = fs_to_bits(cfg.fs);
        vec = '0;
        vec[POS_GEN] = cfg.gen;
        if (is_cd(cfg.fs)) begin
            vec[POS_COPY] = sub.b2;
            vec[POS_EMPH] = sub.b3;
            vec[POS_SUB5] = sub.b5;
            vec[POS_CAT0] = 1'b1;
            vec[POS_CAT1] = 1'b0;
        end else begin
            vec[POS_COPY] = ~cfg.copy_inh;
            vec[POS_EMPH] = cfg.emph;
            vec[POS_CAT0] = cfg.cat[0];
            vec[POS_CAT1] = cfg.cat[1];
        end
        vec[POS_FS0] = fsb[0];
        vec[POS_FS1] = fsb[1];
        bit_out = vec[idx];
    end
endmodule

// File: rtl/cs_consumer_gen.sv
module cs_consumer_gen
    import cscg_pkg::*;
#(
    parameter int unsigned FRAMES      = 192,
    parameter int unsigned START_EDGES = 16,
    parameter int unsigned Q_TAKEN     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_strobe,
    input  logic       copy_inhibit,
    input  logic       emph_on,
    input  logic [1:0] category,
    input  logic       generation,
    input  logic [1:0] fs_code,
    input  logic       sub_frame,
    input  logic       sub_clk,
    input  logic       sub_data,
    output logic       cs_bit,
    output logic       block_start
);
    localparam int unsigned IW = $clog2(FRAMES);

    pin_cfg_t      cfg;
    sub_bits_t     sub_pend, sub_applied;
    logic [IW-1:0] frm_idx;
    logic          wrap, first, cd_mode;

    assign cfg.copy_inh = copy_inhibit;
    assign cfg.emph     = emph_on;
    assign cfg.cat      = category;
    assign cfg.gen      = generation;
    assign cfg.fs       = fs_code_e'(fs_code);
    assign cd_mode      = is_cd(cfg.fs);

    cscg_frame_counter #(.FRAMES(FRAMES)) u_cnt (
        .clk(clk), .rst(rst), .strobe(frame_strobe),
        .idx(frm_idx), .wrap(wrap), .first(first)
    );

    cscg_subcode_rx #(.START_EDGES(START_EDGES), .Q_TAKEN(Q_TAKEN)) u_rx (
        .clk(clk), .rst(rst), .sub_frame(sub_frame), .sub_clk(sub_clk),
        .sub_data(sub_data), .apply(wrap),
        .pending(sub_pend), .applied(sub_applied)
    );

    cscg_status_builder #(.FRAMES(FRAMES)) u_bld (
        .cfg(cfg), .sub(sub_applied), .idx(frm_idx), .bit_out(cs_bit)
    );

    assign block_start = first && !cd_mode;
endmodule

// File: rtl/cs_consumer_gen_chk.sv
module cs_consumer_gen_chk #(
    parameter int unsigned IW = 8,
    parameter int unsigned FRAMES = 192
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_strobe,
    input logic          copy_inhibit,
    input logic [1:0]    fs_code,
    input logic          cs_bit,
    input logic          block_start,
    input logic [IW-1:0] frm_idx,
    input logic [2:0]    sub_applied
);
    localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && frm_idx == LAST) |=> (frm_idx == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |=> $stable(frm_idx));

    p_range_r2: assert property (@(posedge clk) disable iff (rst)
        frm_idx <= LAST);

    p_cd_nostart_r6: assert property (@(posedge clk) disable iff (rst)
        (fs_code == 2'b11) |-> !block_start);

    p_copy_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (fs_code != 2'b11 && copy_inhibit && frm_idx == IW'(2)) |-> !cs_bit);

    p_apply_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        !(frame_strobe && frm_idx == LAST) |=> $stable(sub_applied));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (frm_idx == '0 && sub_applied == 3'b000));
endmodule

bind cs_consumer_gen cs_consumer_gen_chk #(.IW(IW), .FRAMES(FRAMES)) u_chk (
    .clk(clk), .rst(rst), .frame_strobe(frame_strobe),
    .copy_inhibit(copy_inhibit), .fs_code(fs_code), .cs_bit(cs_bit),
    .block_start(block_start), .frm_idx(frm_idx), .sub_applied(sub_applied)
);

// File: tb/cs_consumer_gen_test.sv
module cs_consumer_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_strobe = 1'b0;
    logic copy_inhibit = 1'b0, emph_on = 1'b0, generation = 1'b0;
    logic [1:0] category = 2'b00, fs_code = 2'b00;
    logic sub_frame = 1'b0, sub_clk = 1'b0, sub_data = 1'b0;
    logic cs_bit, block_start;

    int total = 0;
    int bad = 0;
    bit mon_go = 0;

    typedef struct {
        logic  exp_cs;
        logic  exp_bs;
        string tag;
        int    frame;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    cs_consumer_gen uut (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe),
        .copy_inhibit(copy_inhibit), .emph_on(emph_on), .category(category),
        .generation(generation), .fs_code(fs_code), .sub_frame(sub_frame),
        .sub_clk(sub_clk), .sub_data(sub_data), .cs_bit(cs_bit),
        .block_start(block_start)
    );

    // Monitor: pops an expected item and compares at the falling edge
    always @(negedge clk) begin
        if (mon_go && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (cs_bit !== it.exp_cs) begin
                bad++;
                $display("FAIL %s frame %0d cs_bit actual=%b expected=%b",
                         it.tag, it.frame, cs_bit, it.exp_cs);
            end
            total++;
            if (block_start !== it.exp_bs) begin
                bad++;
                $display("FAIL %s frame %0d block_start actual=%b expected=%b",
                         (it.frame == 0) ? "R2" : "R2/R6", it.frame, block_start, it.exp_bs);
            end
            mon_go = 0;
        end
    end

    function automatic logic [191:0] exp_vec(input logic cd, input logic b5,
                                             input logic b2, input logic b3);
        logic [191:0] v = '0;
        v[15] = generation;
        if (cd) begin
            v[2] = b2; v[3] = b3; v[5] = b5; v[8] = 1'b1;
        end else begin
            v[2] = ~copy_inhibit; v[3] = emph_on;
            v[8] = category[0];   v[9] = category[1];
            case (fs_code)
                2'b01: begin v[24] = 1'b0; v[25] = 1'b1; end
                2'b10: begin v[24] = 1'b1; v[25] = 1'b1; end
                default: ;
            endcase
        end
        return v;
    endfunction

    function automatic string tag_of(input int f, input logic cd);
        if (cd) begin
            if (f == 2 || f == 3 || f == 5) return "R7";
            if (f == 8 || f == 9 || f == 24 || f == 25 || f == 15) return "R6";
            return "R10";
        end
        if (f == 2) return "R3";
        if (f == 3 || f == 8 || f == 9 || f == 15) return "R4";
        if (f == 24 || f == 25) return "R5";
        return "R10";
    endfunction

    task automatic strobe();
        frame_strobe = 1'b1;
        @(posedge clk); #1;
        frame_strobe = 1'b0;
    endtask

    // Driver: queues the expected bit of every frame, lets the monitor compare, advances
    task automatic run_block(input logic [191:0] v, input logic cd, input string pre);
        for (int f = 0; f < 192; f++) begin
            item_t it;
            it.exp_cs = v[f];
            it.exp_bs = (f == 0) && !cd;
            it.tag    = (pre.len() > 0 && (f == 2 || f == 3 || f == 5)) ? pre : tag_of(f, cd);
            it.frame  = f;
            sb.push_back(it);
            mon_go = 1;
            @(negedge clk); #1;
            strobe();
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic sub_bit(input logic d);
        sub_data = d;
        wait_clk(2);
        sub_clk = 1'b1;
        wait_clk(2);
        sub_clk = 1'b0;
        wait_clk(2);
    endtask

    task automatic sub_high(input int edges);
        sub_frame = 1'b1;
        wait_clk(2);
        for (int i = 0; i < edges; i++) sub_bit(1'b1);
        sub_frame = 1'b0;
        wait_clk(3);
    endtask

    task automatic sub_q4(input logic q0, input logic q1, input logic q2, input logic q3);
        sub_bit(q0); sub_bit(q1); sub_bit(q2); sub_bit(q3);
    endtask

    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst = 1'b0;
        wait_clk(1);
        // R1: reset state
        total++;
        if (block_start !== 1'b1 || cs_bit !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset block_start/cs_bit actual=%b%b expected=10",
                     block_start, cs_bit);
        end

        // Three pin patterns, one per plain rate code (R2 R3 R4 R5 R10)
        copy_inhibit = 0; emph_on = 1; category = 2'b01; generation = 1; fs_code = 2'b01;
        run_block(exp_vec(0, 0, 0, 0), 0, "");
        copy_inhibit = 1; emph_on = 0; category = 2'b10; generation = 0; fs_code = 2'b10;
        run_block(exp_vec(0, 0, 0, 0), 0, "");
        copy_inhibit = 0; emph_on = 1; category = 2'b11; generation = 1; fs_code = 2'b00;
        run_block(exp_vec(0, 0, 0, 0), 0, "");

        // CD submode with category pins 11 (R6); no subcode yet
        fs_code = 2'b11;
        run_block(exp_vec(1, 0, 0, 0), 1, "");

        // R7: valid start (20 edges), Q = 1,0,1,1 -> b5=1 b2=1 b3=1
        sub_high(20);
        sub_q4(1, 0, 1, 1);
        run_block(exp_vec(1, 0, 0, 0), 1, "R9");   // R9: not yet applied
        run_block(exp_vec(1, 1, 1, 1), 1, "R7");

        // R8: 16 edges is no start; later bits ignored
        sub_high(16);
        sub_q4(0, 0, 0, 0);
        run_block(exp_vec(1, 1, 1, 1), 1, "R8");
        run_block(exp_vec(1, 1, 1, 1), 1, "R8");

        // R1: reset mid-block clears applied bits
        for (int i = 0; i < 50; i++) strobe();
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        wait_clk(1);
        run_block(exp_vec(1, 0, 0, 0), 1, "R1");

        // R7/R8: 17 edges starts; Q = 0,1,0,1 -> b5=0 b2=0 b3=1
        sub_high(17);
        sub_q4(0, 1, 0, 1);
        run_block(exp_vec(1, 0, 0, 0), 1, "R9");
        run_block(exp_vec(1, 0, 0, 1), 1, "R7");

        // Back to normal mode: block_start returns at frame 0 (R2)
        fs_code = 2'b01; copy_inhibit = 1;
        run_block(exp_vec(0, 0, 0, 0), 0, "");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule